// File: doc/BRIEF.md
# Quasi-Resonant Flyback Switching Sequencer

This block generates the gate drive for the primary switch of a flyback converter operating at the boundary between continuous and discontinuous conduction. Its inputs are comparator results that have already been synchronised to the clock:
- a flag that is high while the auxiliary-winding sense voltage sits below its zero-energy low threshold;
- a flag for the high threshold;
- an end-of-on request from an external ramp comparator;
- a peak-current limit flag;
- an enable from the protection supervisor.

In normal operation the switch closes a programmable number of clocks after the sense voltage drops through the low threshold. This lets the drain ring down to its valley before turn-on.

Every timing bound is a parameter counted in clock cycles. The defaults assume a 100 MHz clock. The bounds are:
- minimum and maximum on-time;
- minimum off-time;
- minimum switching period;
- maximum off-time, which restarts switching when no crossing arrives.

After enable the block first runs a forced-switching start-up mode with a fixed on-time and a bounded off-time. It leaves that mode the first time the high-threshold flag is seen. A low-frequency request from the protection logic reapplies the same fixed timing. A one-clock strobe marks the start of every on-phase.

Top module: `qr_sequencer`

## Requirements
- R1: While reset is asserted, or on the clock after enable is seen low, the drive output and the strobe are low. All timers restart, and the next enable re-enters the start-up forced mode.
- R2: A crossing is the first clock edge that samples `zeroLow` high after it was low. When a crossing is accepted, the drive rises `adjDelay`+1 clock edges later.
- R3: In normal mode the drive stays high for at least MIN_ON_CYC cycles, even when `onDone` is already high at turn-on.
- R4: In normal mode the drive is forced low after MAX_ON_CYC high cycles when `onDone` never asserts.
- R5: In normal mode a crossing is accepted only if both limits are already met on that edge: the drive has been low for at least MIN_OFF_CYC cycles, and at least MIN_PERIOD_CYC cycles have passed since the drive rose. A crossing that arrives earlier is ignored.
- R6: In normal mode, if no crossing is accepted, the drive rises again after exactly MAX_OFF_CYC low cycles.
- R7: After enable, the forced mode holds the drive high for exactly FORCE_ON_CYC cycles and ignores `onDone`. The forced off-phase works as follows:
  - It ends after exactly FORCE_OFF_MAX_CYC low cycles.
  - It ends earlier on a crossing once FORCE_OFF_MIN_CYC low cycles have passed.
  - Forced mode is left once `zeroHigh` is sampled high.
- R8: A high `peakLimit` during an on-phase drops the drive in the same cycle, regardless of the minimum on-time. The following on-phase starts only after a later accepted crossing or the off-time timeout.
- R9: While `lowFreqReq` is high the block uses the forced on-time and off-time bounds. After it falls, normal timing resumes.
- R10: `cycleStrobe` is high for exactly one clock, the first clock of every on-phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Switching permitted by the protection supervisor |
| zeroLow | input | 1 | High while the sense voltage is below the low threshold |
| zeroHigh | input | 1 | High while the sense voltage is above the high threshold |
| onDone | input | 1 | End-of-on request from the ramp comparator |
| peakLimit | input | 1 | Primary peak-current limit reached |
| lowFreqReq | input | 1 | Request for forced fixed-timing operation |
| adjDelay | input | ADJ_W | Turn-on delay after a crossing, in clocks |
| gateOut | output | 1 | Switch gate drive |
| cycleStrobe | output | 1 | One-clock pulse at the start of each on-phase |

## Verification
The bench shrinks every timing bound to a few tens of clocks, with the following values:

| Parameter | Value |
|-----------|-------|
| MIN_ON_CYC | 5 |
| MAX_ON_CYC | 40 |
| MIN_OFF_CYC | 8 |
| MIN_PERIOD_CYC | 30 |
| MAX_OFF_CYC | 200 |
| FORCE_ON_CYC | 10 |
| FORCE_OFF_MIN_CYC | 50 |
| FORCE_OFF_MAX_CYC | 120 |

With these values the exact edges of each window can be hit within a short run. These include the crossing one clock before and exactly at the minimum off-time, and one clock before and at the minimum period. The values are distinct, so a check can tell which bound ended an off-phase: forced timeout, normal timeout or a delayed crossing.

// File: rtl/qrs_pkg.sv
package qrs_pkg;

  typedef enum logic [1:0] {
    PH_STOP = 2'd0,
    PH_ON   = 2'd1,
    PH_OFF  = 2'd2,
    PH_ADJ  = 2'd3
  } phase_e;

  // Control -> datapath strobes
  typedef struct packed {
    logic clearAll;
    logic startOn;
    logic startOff;
    logic startAdj;
    logic byPeak;
  } seq_strobe_t;

  // Datapath -> control comparisons
  typedef struct packed {
    logic zeroEdge;
    logic onMinMet;
    logic onMaxHit;
    logic onForcedDone;
    logic offMinOk;
    logic perMinOk;
    logic offMaxHit;
    logic fOffMinOk;
    logic fOffMaxHit;
    logic adjDone;
  } seq_status_t;

endpackage

// File: rtl/qrs_datapath.sv
module qrs_datapath
  import qrs_pkg::*;
#(
  parameter int MIN_ON_CYC        = 50,
  parameter int MAX_ON_CYC        = 4400,
  parameter int MIN_OFF_CYC       = 150,
  parameter int MIN_PERIOD_CYC    = 750,
  parameter int MAX_OFF_CYC       = 32000,
  parameter int FORCE_ON_CYC      = 150,
  parameter int FORCE_OFF_MIN_CYC = 7800,
  parameter int FORCE_OFF_MAX_CYC = 32000,
  parameter int ADJ_W             = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             zeroLow,
  input  logic [ADJ_W-1:0] adjDelay,
  input  logic             onPhase,
  input  seq_strobe_t      stb,
  output seq_status_t      status
);

  localparam int TOP_A = (MAX_OFF_CYC > FORCE_OFF_MAX_CYC) ? MAX_OFF_CYC : FORCE_OFF_MAX_CYC;
  localparam int TOP_B = (TOP_A > MIN_PERIOD_CYC) ? TOP_A : MIN_PERIOD_CYC;
  localparam int TOP_C = (TOP_B > MAX_ON_CYC) ? TOP_B : MAX_ON_CYC;
  localparam int CW    = $clog2(TOP_C + 1);
  localparam int NCNT  = 2;

  localparam logic [CW-1:0] CNT_SAT    = '1;
  localparam logic [CW-1:0] ON_MIN_L   = CW'(MIN_ON_CYC - 1);
  localparam logic [CW-1:0] ON_MAX_L   = CW'(MAX_ON_CYC - 1);
  localparam logic [CW-1:0] ON_FRC_L   = CW'(FORCE_ON_CYC - 1);
  localparam logic [CW-1:0] OFF_MIN_L  = CW'(MIN_OFF_CYC - 1);
  localparam logic [CW-1:0] PER_MIN_L  = CW'(MIN_PERIOD_CYC - 1);
  localparam logic [CW-1:0] OFF_MAX_L  = CW'(MAX_OFF_CYC - 1);
  localparam logic [CW-1:0] FOFF_MIN_L = CW'(FORCE_OFF_MIN_CYC - 1);
  localparam logic [CW-1:0] FOFF_MAX_L = CW'(FORCE_OFF_MAX_CYC - 1);
  localparam logic [ADJ_W-1:0] ADJ_SAT = '1;

  // Counter 0 runs from each turn-on (on-time and period), counter 1 from each turn-off.
  logic [NCNT-1:0] cntClr;
  logic [CW-1:0]   cnt [NCNT];
  logic [CW-1:0]   periodCnt;
  logic [CW-1:0]   offCnt;
  logic [ADJ_W-1:0] adjCnt;
  logic            zlPrev;

  assign cntClr[0] = stb.clearAll | stb.startOn;
  assign cntClr[1] = stb.clearAll | stb.startOff;

  for (genvar g = 0; g < NCNT; g++) begin : gCnt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                cnt[g] <= '0;
      else if (cntClr[g])       cnt[g] <= '0;
      else if (cnt[g] != CNT_SAT) cnt[g] <= cnt[g] + 1'b1;
    end
  end

  assign periodCnt = cnt[0];
  assign offCnt    = cnt[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         adjCnt <= '0;
    else if (stb.clearAll | stb.startAdj) adjCnt <= '0;
    else if (adjCnt != ADJ_SAT)        adjCnt <= adjCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) zlPrev <= 1'b0;
    else       zlPrev <= zeroLow;
  end

  always_comb begin
    status.zeroEdge     = zeroLow & ~zlPrev;
    status.onMinMet     = periodCnt >= ON_MIN_L;
    status.onMaxHit     = periodCnt >= ON_MAX_L;
    status.onForcedDone = periodCnt >= ON_FRC_L;
    status.offMinOk     = offCnt >= OFF_MIN_L;
    status.perMinOk     = periodCnt >= PER_MIN_L;
    status.offMaxHit    = offCnt >= OFF_MAX_L;
    status.fOffMinOk    = offCnt >= FOFF_MIN_L;
    status.fOffMaxHit   = offCnt >= FOFF_MAX_L;
    status.adjDone      = adjCnt >= adjDelay;
  end

  // R4
  on_max_chk: assert property (@(posedge clk) disable iff (!rstN)
    onPhase |-> (periodCnt <= ON_MAX_L));

  // R3 (forced on-time is configured no shorter than the normal minimum)
  on_min_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.startOff && !stb.byPeak) |-> (periodCnt >= ON_MIN_L));

  // R5 (forced minimum off-time is configured no shorter than the normal one)
  off_min_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.startAdj |-> (offCnt >= OFF_MIN_L));

endmodule

// File: rtl/qrs_control.sv
module qrs_control
  import qrs_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        zeroHigh,
  input  logic        onDone,
  input  logic        peakLimit,
  input  logic        lowFreqReq,
  input  seq_status_t status,
  output seq_strobe_t stb,
  output logic        onPhase,
  output logic        cycleStrobe
);

  phase_e phase, phaseNxt;
  logic   startMode;
  logic   forced;
  logic   strobeQ;
  logic   peakCut;

  assign forced = startMode | lowFreqReq;

  always_comb begin
    phaseNxt = phase;
    peakCut  = 1'b0;
    unique case (phase)
      PH_STOP: if (enable) phaseNxt = PH_ON;
      PH_ON: begin
        if (peakLimit) begin
          phaseNxt = PH_OFF;
          peakCut  = 1'b1;
        end else if (forced ? status.onForcedDone
                            : ((status.onMinMet && onDone) || status.onMaxHit)) begin
          phaseNxt = PH_OFF;
        end
      end
      PH_OFF: begin
        if (status.zeroEdge && (forced ? status.fOffMinOk
                                       : (status.offMinOk && status.perMinOk)))
          phaseNxt = PH_ADJ;
        else if (forced ? status.fOffMaxHit : status.offMaxHit)
          phaseNxt = PH_ON;
      end
      PH_ADJ: if (status.adjDone) phaseNxt = PH_ON;
      default: phaseNxt = PH_STOP;
    endcase
    if (!enable) phaseNxt = PH_STOP;
  end

  always_comb begin
    stb.clearAll = ~enable;
    stb.startOn  = enable && (phaseNxt == PH_ON)  && (phase != PH_ON);
    stb.startOff = enable && (phaseNxt == PH_OFF) && (phase == PH_ON);
    stb.startAdj = enable && (phaseNxt == PH_ADJ) && (phase == PH_OFF);
    stb.byPeak   = stb.startOff && peakCut;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_STOP;
      startMode <= 1'b1;
      strobeQ   <= 1'b0;
    end else begin
      phase   <= phaseNxt;
      strobeQ <= stb.startOn;
      if (!enable)       startMode <= 1'b1;
      else if (zeroHigh) startMode <= 1'b0;
    end
  end

  assign onPhase     = (phase == PH_ON);
  assign cycleStrobe = strobeQ;

  // R10
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cycleStrobe |=> !cycleStrobe);

  // R10
  strobe_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    cycleStrobe |-> onPhase);

  // R8
  peak_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (onPhase && peakLimit) |=> !onPhase);

endmodule

// File: rtl/qr_sequencer.sv
module qr_sequencer
  import qrs_pkg::*;
#(
  parameter int MIN_ON_CYC        = 50,
  parameter int MAX_ON_CYC        = 4400,
  parameter int MIN_OFF_CYC       = 150,
  parameter int MIN_PERIOD_CYC    = 750,
  parameter int MAX_OFF_CYC       = 32000,
  parameter int FORCE_ON_CYC      = 150,
  parameter int FORCE_OFF_MIN_CYC = 7800,
  parameter int FORCE_OFF_MAX_CYC = 32000,
  parameter int ADJ_W             = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             zeroLow,
  input  logic             zeroHigh,
  input  logic             onDone,
  input  logic             peakLimit,
  input  logic             lowFreqReq,
  input  logic [ADJ_W-1:0] adjDelay,
  output logic             gateOut,
  output logic             cycleStrobe
);

  seq_strobe_t stb;
  seq_status_t status;
  logic        onPhase;

  qrs_control u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .zeroHigh    (zeroHigh),
    .onDone      (onDone),
    .peakLimit   (peakLimit),
    .lowFreqReq  (lowFreqReq),
    .status      (status),
    .stb         (stb),
    .onPhase     (onPhase),
    .cycleStrobe (cycleStrobe)
  );

  qrs_datapath #(
    .MIN_ON_CYC        (MIN_ON_CYC),
    .MAX_ON_CYC        (MAX_ON_CYC),
    .MIN_OFF_CYC       (MIN_OFF_CYC),
    .MIN_PERIOD_CYC    (MIN_PERIOD_CYC),
    .MAX_OFF_CYC       (MAX_OFF_CYC),
    .FORCE_ON_CYC      (FORCE_ON_CYC),
    .FORCE_OFF_MIN_CYC (FORCE_OFF_MIN_CYC),
    .FORCE_OFF_MAX_CYC (FORCE_OFF_MAX_CYC),
    .ADJ_W             (ADJ_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .zeroLow  (zeroLow),
    .adjDelay (adjDelay),
    .onPhase  (onPhase),
    .stb      (stb),
    .status   (status)
  );

  // Peak limit cuts the drive without waiting for a clock edge.
  assign gateOut = onPhase & ~peakLimit;

  // R1
  disable_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !gateOut);

endmodule

// File: tb/sim_qr_sequencer.sv
module sim_qr_sequencer;

  localparam int T_MIN_ON  = 5;
  localparam int T_MAX_ON  = 40;
  localparam int T_MIN_OFF = 8;
  localparam int T_MIN_PER = 30;
  localparam int T_MAX_OFF = 200;
  localparam int T_F_ON    = 10;
  localparam int T_F_MIN   = 50;
  localparam int T_F_MAX   = 120;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       zeroLow = 1'b0;
  logic       zeroHigh = 1'b0;
  logic       onDone = 1'b0;
  logic       peakLimit = 1'b0;
  logic       lowFreqReq = 1'b0;
  logic [7:0] adjDelay = 8'd0;
  logic       gateOut;
  logic       cycleStrobe;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  qr_sequencer #(
    .MIN_ON_CYC(T_MIN_ON), .MAX_ON_CYC(T_MAX_ON), .MIN_OFF_CYC(T_MIN_OFF),
    .MIN_PERIOD_CYC(T_MIN_PER), .MAX_OFF_CYC(T_MAX_OFF), .FORCE_ON_CYC(T_F_ON),
    .FORCE_OFF_MIN_CYC(T_F_MIN), .FORCE_OFF_MAX_CYC(T_F_MAX), .ADJ_W(8)
  ) u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .zeroLow(zeroLow), .zeroHigh(zeroHigh),
    .onDone(onDone), .peakLimit(peakLimit), .lowFreqReq(lowFreqReq),
    .adjDelay(adjDelay), .gateOut(gateOut), .cycleStrobe(cycleStrobe)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic checkEq(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  // Starts on a negedge with the drive high; returns high length and strobe count.
  task automatic countHigh(output int hi, output int strobes);
    hi = 0; strobes = 0;
    while (gateOut && hi < 1000) begin
      hi++;
      if (cycleStrobe) strobes++;
      tick();
    end
  endtask

  // Starts on the first low negedge; raises zeroLow at low sample c (0 = never).
  task automatic cycleOff(input int c, input int d, output int lowN);
    adjDelay = 8'(d);
    lowN = 1;
    forever begin
      if (lowN == c) zeroLow = 1'b1;
      tick();
      if (gateOut || lowN > 1000) break;
      lowN++;
    end
    zeroLow = 1'b0;
  endtask

  task automatic waitRise(output int n);
    n = 0;
    do begin tick(); n++; end while (!gateOut && n < 1000);
  endtask

  task automatic t_reset();
    repeat (4) tick();
    checkEq("R1 gate in reset", int'(gateOut), 0);
    checkEq("R1 strobe in reset", int'(cycleStrobe), 0);
    rstN = 1'b1;
    tick();
    checkEq("R1 gate idle", int'(gateOut), 0);
  endtask

  task automatic t_startup();
    int hi, s, lo;
    onDone = 1'b1; enable = 1'b1;
    tick();
    checkEq("R7 drive starts after enable", int'(gateOut), 1);
    checkEq("R10 strobe on first on clock", int'(cycleStrobe), 1);
    countHigh(hi, s);
    checkEq("R7 forced on-time ignores onDone", hi, T_F_ON);
    checkEq("R10 one strobe per on-phase", s, 1);
    cycleOff(0, 0, lo);
    checkEq("R7 forced off timeout", lo, T_F_MAX);
    countHigh(hi, s);
    checkEq("R7 forced on-time second cycle", hi, T_F_ON);
    cycleOff(60, 3, lo);
    checkEq("R7 R2 forced crossing with delay", lo, 60 + 3 + 1);
    zeroHigh = 1'b1; tick(); zeroHigh = 1'b0;
    countHigh(hi, s);
  endtask

  task automatic t_normal_on();
    int hi, s, lo;
    cycleOff(40, 3, lo);
    checkEq("R2 valley delay 3", lo, 44);
    countHigh(hi, s);
    checkEq("R3 minimum on-time", hi, T_MIN_ON);
    onDone = 1'b0;
    cycleOff(40, 10, lo);
    checkEq("R2 valley delay 10", lo, 51);
    countHigh(hi, s);
    checkEq("R4 maximum on-time", hi, T_MAX_ON);
    checkEq("R10 strobe count long cycle", s, 1);
  endtask

  task automatic t_off_limits();
    int hi, s, lo;
    cycleOff(7, 0, lo);
    checkEq("R5 crossing before min off ignored / R6 timeout", lo, T_MAX_OFF);
    countHigh(hi, s);
    cycleOff(8, 0, lo);
    checkEq("R5 crossing at min off accepted", lo, 9);
    countHigh(hi, s);
    onDone = 1'b1;
    cycleOff(30, 2, lo);
    checkEq("R5 R2 crossing after period", lo, 33);
    countHigh(hi, s);
    checkEq("R3 short on-time", hi, T_MIN_ON);
    cycleOff(24, 0, lo);
    checkEq("R5 crossing before min period ignored", lo, T_MAX_OFF);
    countHigh(hi, s);
    cycleOff(25, 0, lo);
    checkEq("R5 crossing at min period accepted", lo, 26);
    countHigh(hi, s);
  endtask

  task automatic t_peak();
    int hi, s, lo, n;
    onDone = 1'b0;
    cycleOff(40, 0, lo);
    checkEq("R2 zero delay", lo, 41);
    tick(); tick();
    checkEq("R8 drive high before limit", int'(gateOut), 1);
    peakLimit = 1'b1;
    #1;
    checkEq("R8 drive drops in same cycle", int'(gateOut), 0);
    tick();
    peakLimit = 1'b0;
    #1;
    checkEq("R8 on-phase ended", int'(gateOut), 0);
    repeat (30) tick();
    checkEq("R8 no restart without crossing", int'(gateOut), 0);
    zeroLow = 1'b1;
    waitRise(n);
    zeroLow = 1'b0;
    checkEq("R8 restart on later crossing", n, 2);
    countHigh(hi, s);
    checkEq("R4 on-time after peak cycle", hi, T_MAX_ON);
  endtask

  task automatic t_lowfreq();
    int hi, s, lo;
    onDone = 1'b1; lowFreqReq = 1'b1;
    cycleOff(0, 0, lo);
    checkEq("R9 forced off timeout", lo, T_F_MAX);
    countHigh(hi, s);
    checkEq("R9 forced on-time", hi, T_F_ON);
    lowFreqReq = 1'b0;
    cycleOff(25, 0, lo);
    checkEq("R9 normal crossing after release", lo, 26);
    countHigh(hi, s);
    checkEq("R9 normal on-time after release", hi, T_MIN_ON);
  endtask

  task automatic t_disable();
    int hi, s, lo;
    onDone = 1'b0;
    cycleOff(40, 0, lo);
    tick(); tick();
    enable = 1'b0;
    tick();
    checkEq("R1 drive low after disable", int'(gateOut), 0);
    checkEq("R1 strobe low after disable", int'(cycleStrobe), 0);
    repeat (5) tick();
    checkEq("R1 drive stays low", int'(gateOut), 0);
    onDone = 1'b1; enable = 1'b1;
    tick();
    checkEq("R1 restart after enable", int'(gateOut), 1);
    countHigh(hi, s);
    checkEq("R1 R7 forced mode re-entered", hi, T_F_ON);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_startup();
        t_normal_on();
        t_off_limits();
        t_peak();
        t_lowfreq();
        t_disable();
      end
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule